// File: doc/BRIEF.md
# Mailbox Command Responder

The responder takes command packets from a 32-bit valid/ready stream with start- and end-of-packet marks. Each packet is assumed well formed, meaning its header length matches the words sent. It answers each command with a response packet on a second stream of the same shape.

The command header and the response header share one layout:
- bits [27:24] hold a 4-bit transaction ID;
- bits [22:12] hold an 11-bit argument count;
- bits [10:0] hold an 11-bit code field.

In a command, the code field carries the command code. In a response, it carries an error code, which is 0 on success. Bits [31:28], 23 and 11 are reserved.

Five information queries are answered: a no-op, an identification word, a 64-bit chip identifier, a user code word and a voltage read. The voltage read selects channels with a bitmask. The identifier values and the sensor readings come from input ports. Malformed requests get an error header with no arguments.

Only one command is in flight at a time. The command side stalls from the last word of a command until its response has fully drained, so the two streams never overlap.

Top module: `mbox_responder`

## Requirements
- R1: Response header: bits [27:24] echo the command ID, bits [22:12] give the number of words that follow, bits [10:0] give the error code, and bits [31:28], 23 and 11 are 0 whatever the command header held there.
- R2: Code 0x000 with argument count 0 returns a single header word with error 0, marked both start and end of packet.
- R3: Code 0x010 with count 0 returns one word equal to `id_word_i`; code 0x013 with count 0 returns one word equal to `user_word_i`.
- R4: Code 0x012 with count 0 returns two words: `chip_id_i[31:0]` first, then `chip_id_i[63:32]`.
- R5: Code 0x018 with count 1 treats the argument as a channel mask and returns one word per set bit in ascending channel order. The word for channel c is `volt_i[32*c +: 32]`, an unsigned value with 16 fractional bits (0.75 V = 0x0000C000).
- R6: Any other code returns error 0x003 and argument count 0.
- R7: A supported code whose argument count differs from its expected count (0, or 1 for 0x018) returns error 0x004 and count 0. This check ranks after R6 and before R8.
- R8: For code 0x018 with a correct count, a mask that is zero or has any bit set at or above NUM_CH returns error 0x009 and count 0.
- R9: A response word is held unchanged while `rsp_ready_i` is low. The start mark appears only on the header. The end mark appears only on the last word, which is the header when the count is 0.
- R10: After reset, `cmd_ready_o` is 1 and `rsp_valid_o` is 0. `cmd_ready_o` is 0 from the cycle after a command's last word is taken until the last response word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Command word accepted this cycle when valid |
| cmd_data_i | input | 32 | Command word |
| cmd_sop_i | input | 1 | First word of a command (header) |
| cmd_eop_i | input | 1 | Last word of a command |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_ready_i | input | 1 | Downstream can take the response word |
| rsp_data_o | output | 32 | Response word |
| rsp_sop_o | output | 1 | Response header word |
| rsp_eop_o | output | 1 | Last response word |
| id_word_i | input | 32 | Identification code returned by 0x010 |
| user_word_i | input | 32 | User code returned by 0x013 |
| chip_id_i | input | 64 | Chip identifier returned by 0x012 |
| volt_i | input | 32*NUM_CH | Voltage reading per channel |

## Verification
The assertions check the following on every cycle:
- a stalled response word stays frozen;
- a header carrying an error code is always the only word of its packet, with a zero count;
- the voltage header count matches the population of the mask being walked;
- the command side stays blocked while a response is pending.

The encoding itself can only be shown by the bench's scenarios, since it needs a model of the expected result. That covers each query's data words and their order, the ranking of unknown-code, bad-count and bad-mask errors, and the clearing of reserved header bits. The bench's scenarios also show that `cmd_ready_o` returns high once a response drains.

// File: rtl/mbox_resp_pkg.sv
`timescale 1ns/1ps
package mbox_resp_pkg;
  localparam logic [10:0] CODE_NOOP  = 11'h000;
  localparam logic [10:0] CODE_IDW   = 11'h010;
  localparam logic [10:0] CODE_CHIP  = 11'h012;
  localparam logic [10:0] CODE_USER  = 11'h013;
  localparam logic [10:0] CODE_VOLT  = 11'h018;

  localparam logic [10:0] ERR_OK      = 11'h000;
  localparam logic [10:0] ERR_UNKNOWN = 11'h003;
  localparam logic [10:0] ERR_BADLEN  = 11'h004;
  localparam logic [10:0] ERR_BADMASK = 11'h009;

  typedef struct packed {
    logic [3:0]  rsvd_hi;
    logic [3:0]  id;
    logic        rsvd_a;
    logic [10:0] len;
    logic        rsvd_b;
    logic [10:0] code;
  } mbox_hdr_t;
endpackage

// File: rtl/mbox_cmd_rx.sv
`timescale 1ns/1ps
module mbox_cmd_rx
  import mbox_resp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic [31:0] cmd_data_i,
  input  logic        cmd_sop_i,
  input  logic        cmd_eop_i,
  input  logic        tx_busy_i,
  input  logic        take_i,
  output logic        pend_o,
  output mbox_hdr_t   hdr_o,
  output logic [31:0] arg_o
);
  logic      pend_q, arg_seen_q;
  mbox_hdr_t hdr_q;
  logic [31:0] arg_q;
  logic      hs;

  assign cmd_ready_o = !pend_q && !tx_busy_i;
  assign hs          = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      arg_seen_q <= 1'b0;
      hdr_q      <= '0;
      arg_q      <= '0;
    end else begin
      if (take_i) pend_q <= 1'b0;
      if (hs) begin
        if (cmd_sop_i) begin
          hdr_q      <= mbox_hdr_t'(cmd_data_i);
          arg_q      <= '0;
          arg_seen_q <= 1'b0;
        end else if (!arg_seen_q) begin
          arg_q      <= cmd_data_i;
          arg_seen_q <= 1'b1;
        end
        if (cmd_eop_i) pend_q <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign hdr_o  = hdr_q;
  assign arg_o  = arg_q;

  // R10
  eop_blocks_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && cmd_eop_i |=> !cmd_ready_o);
endmodule

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
  import mbox_resp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  mbox_hdr_t         hdr_i,
  input  logic [31:0]       arg_i,
  output logic [10:0]       err_o,
  output logic [10:0]       len_o,
  output logic [NUM_CH-1:0] mask_o
);
  localparam logic [31:0] LO_MASK = (32'd1 << NUM_CH) - 32'd1;

  logic        known;
  logic [10:0] exp_len, ok_len, pop;
  logic        mask_ok;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_CH; i++) pop = pop + 11'(arg_i[i]);
  end

  assign mask_ok = (arg_i[NUM_CH-1:0] != '0) && ((arg_i & ~LO_MASK) == '0);

  always_comb begin
    known   = 1'b1;
    exp_len = '0;
    ok_len  = '0;
    unique case (hdr_i.code)
      CODE_NOOP: ok_len = 11'd0;
      CODE_IDW:  ok_len = 11'd1;
      CODE_USER: ok_len = 11'd1;
      CODE_CHIP: ok_len = 11'd2;
      CODE_VOLT: begin exp_len = 11'd1; ok_len = pop; end
      default:   known = 1'b0;
    endcase
    if (!known) begin
      err_o = ERR_UNKNOWN; len_o = '0;
    end else if (hdr_i.len != exp_len) begin
      err_o = ERR_BADLEN;  len_o = '0;
    end else if (hdr_i.code == CODE_VOLT && !mask_ok) begin
      err_o = ERR_BADMASK; len_o = '0;
    end else begin
      err_o = ERR_OK;      len_o = ok_len;
    end
  end

  assign mask_o = arg_i[NUM_CH-1:0];
endmodule

// File: rtl/mbox_rsp_tx.sv
`timescale 1ns/1ps
module mbox_rsp_tx
  import mbox_resp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         id_i,
  input  logic [10:0]        code_i,
  input  logic [10:0]        err_i,
  input  logic [10:0]        len_i,
  input  logic [NUM_CH-1:0]  mask_i,
  input  logic [31:0]        id_word_i,
  input  logic [31:0]        user_word_i,
  input  logic [63:0]        chip_id_i,
  input  logic [32*NUM_CH-1:0] volt_i,
  output logic               busy_o,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [31:0]        rsp_data_o,
  output logic               rsp_sop_o,
  output logic               rsp_eop_o
);
  localparam int SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              active_q, hdr_ph_q, hi_q;
  logic [3:0]        id_q;
  logic [10:0]       code_q, err_q, len_q, cnt_q;
  logic [NUM_CH-1:0] mask_q;
  logic [SW-1:0]     sel;
  logic              hs;
  mbox_hdr_t         hdr;
  logic [31:0]       dword;

  always_comb begin
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (mask_q[i]) sel = SW'(i);
  end

  assign hs = active_q && rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; hdr_ph_q <= 1'b0; hi_q <= 1'b0;
      id_q <= '0; code_q <= '0; err_q <= '0; len_q <= '0; cnt_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      active_q <= 1'b1; hdr_ph_q <= 1'b1; hi_q <= 1'b0;
      id_q <= id_i; code_q <= code_i; err_q <= err_i;
      len_q <= len_i; cnt_q <= len_i; mask_q <= mask_i;
    end else if (hs) begin
      if (hdr_ph_q) begin
        hdr_ph_q <= 1'b0;
        if (len_q == '0) active_q <= 1'b0;
      end else begin
        cnt_q       <= cnt_q - 11'd1;
        hi_q        <= 1'b1;
        mask_q[sel] <= 1'b0;
        if (cnt_q == 11'd1) active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    hdr = '0;
    hdr.id   = id_q;
    hdr.len  = len_q;
    hdr.code = err_q;
    unique case (code_q)
      CODE_IDW:  dword = id_word_i;
      CODE_USER: dword = user_word_i;
      CODE_CHIP: dword = hi_q ? chip_id_i[63:32] : chip_id_i[31:0];
      CODE_VOLT: dword = volt_i[32*sel +: 32];
      default:   dword = '0;
    endcase
  end

  assign busy_o      = active_q;
  assign rsp_valid_o = active_q;
  assign rsp_data_o  = hdr_ph_q ? hdr : dword;
  assign rsp_sop_o   = active_q && hdr_ph_q;
  assign rsp_eop_o   = active_q && (hdr_ph_q ? (len_q == '0) : (cnt_q == 11'd1));

  // R9
  stable_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o)
      && $stable(rsp_sop_o) && $stable(rsp_eop_o));
  // R9
  single_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_sop_o && rsp_ready_i && !rsp_eop_o |=> rsp_valid_o && !rsp_sop_o);
  // R6 R7 R8
  err_no_args_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_sop_o && rsp_data_o[10:0] != '0 |-> rsp_data_o[22:12] == '0 && rsp_eop_o);
  // R5
  volt_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_sop_o && code_q == CODE_VOLT && rsp_data_o[10:0] == '0
      |-> rsp_data_o[22:12] == 11'($countones(mask_q)));
endmodule

// File: rtl/mbox_responder.sv
`timescale 1ns/1ps
module mbox_responder
  import mbox_resp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [31:0]          cmd_data_i,
  input  logic                 cmd_sop_i,
  input  logic                 cmd_eop_i,
  output logic                 rsp_valid_o,
  input  logic                 rsp_ready_i,
  output logic [31:0]          rsp_data_o,
  output logic                 rsp_sop_o,
  output logic                 rsp_eop_o,
  input  logic [31:0]          id_word_i,
  input  logic [31:0]          user_word_i,
  input  logic [63:0]          chip_id_i,
  input  logic [32*NUM_CH-1:0] volt_i
);
  mbox_hdr_t         hdr;
  logic [31:0]       arg;
  logic              pend, busy, take;
  logic [10:0]       err, len;
  logic [NUM_CH-1:0] mask;

  assign take = pend && !busy;

  mbox_cmd_rx u_rx (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_data_i, .cmd_sop_i, .cmd_eop_i,
    .tx_busy_i(busy), .take_i(take), .pend_o(pend), .hdr_o(hdr), .arg_o(arg)
  );

  mbox_decode #(.NUM_CH(NUM_CH)) u_dec (
    .hdr_i(hdr), .arg_i(arg), .err_o(err), .len_o(len), .mask_o(mask)
  );

  mbox_rsp_tx #(.NUM_CH(NUM_CH)) u_tx (
    .clk_i, .rst_ni, .start_i(take), .id_i(hdr.id), .code_i(hdr.code),
    .err_i(err), .len_i(len), .mask_i(mask),
    .id_word_i, .user_word_i, .chip_id_i, .volt_i,
    .busy_o(busy), .rsp_valid_o, .rsp_ready_i, .rsp_data_o, .rsp_sop_o, .rsp_eop_o
  );

  // R10
  busy_blocks_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/mbox_responder_test.sv
`timescale 1ns/1ps
module mbox_responder_test;
  localparam int NCH = 4;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_sop = 0, cmd_eop = 0, rsp_ready = 0;
  logic [31:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, rsp_sop, rsp_eop;
  logic [31:0] rsp_data;
  logic [31:0] id_word = 32'h0ABC_D0DD, user_word = 32'h5EED_1234;
  logic [63:0] chip_id = 64'h1122_3344_5566_7788;
  logic [32*NCH-1:0] volt;

  initial for (int c = 0; c < NCH; c++) volt[32*c +: 32] = 32'h0000_C000 + 32'(c) * 32'h100;

  mbox_responder #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .cmd_sop_i(cmd_sop), .cmd_eop_i(cmd_eop),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .rsp_sop_o(rsp_sop), .rsp_eop_o(rsp_eop), .id_word_i(id_word),
    .user_word_i(user_word), .chip_id_i(chip_id), .volt_i(volt)
  );

  typedef struct { logic [31:0] d; logic s; logic e; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit running = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(logic [3:0] id, logic [10:0] len, logic [10:0] code);
    return {4'h0, id, 1'b0, len, 1'b0, code};
  endfunction

  task automatic push(logic [31:0] d, logic s, logic e, string tag);
    item_t it;
    it.d = d; it.s = s; it.e = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // expected response model, from the requirements
  task automatic model(logic [3:0] id, logic [10:0] code, logic [10:0] len, logic [31:0] arg);
    logic [10:0] err, n, exp_len;
    bit known;
    known = 1; exp_len = 0;
    case (code)
      11'h000, 11'h010, 11'h012, 11'h013: exp_len = 0;
      11'h018: exp_len = 1;
      default: known = 0;
    endcase
    n = 0;
    if (!known) err = 11'h003;                               // R6
    else if (len != exp_len) err = 11'h004;                  // R7
    else if (code == 11'h018 && (arg[NCH-1:0] == 0 || (arg >> NCH) != 0)) err = 11'h009; // R8
    else begin
      err = 0;
      case (code)
        11'h010, 11'h013: n = 1;
        11'h012: n = 2;
        11'h018: for (int c = 0; c < NCH; c++) n = n + 11'(arg[c]);
        default: n = 0;
      endcase
    end
    push(mk_hdr(id, n, err), 1'b1, n == 0, "R1 header");
    case (code)
      11'h010: if (n != 0) push(id_word, 1'b0, 1'b1, "R3 idword");
      11'h013: if (n != 0) push(user_word, 1'b0, 1'b1, "R3 userword");
      11'h012: if (n != 0) begin
        push(chip_id[31:0], 1'b0, 1'b0, "R4 chip low");
        push(chip_id[63:32], 1'b0, 1'b1, "R4 chip high");
      end
      11'h018: if (n != 0) begin
        int k;
        k = 0;
        for (int c = 0; c < NCH; c++) if (arg[c]) begin
          k++;
          push(volt[32*c +: 32], 1'b0, k == int'(n), "R5 volt");
        end
      end
      default: ;
    endcase
  endtask

  task automatic put_word(logic [31:0] d, logic s, logic e);
    cmd_valid = 1; cmd_data = d; cmd_sop = s; cmd_eop = e;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_sop = 0; cmd_eop = 0;
  endtask

  task automatic send(logic [3:0] rsv, logic [3:0] id, logic [10:0] code, logic [10:0] len,
                      logic [31:0] arg);
    model(id, code, len, arg);
    put_word({rsv, id, 1'b0, len, 1'b0, code}, 1'b1, len == 0);
    for (int i = 0; i < int'(len); i++)
      put_word(i == 0 ? arg : 32'h0, 1'b0, i == int'(len) - 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk); #0.5;
    chk(cmd_ready === 1'b1, "R10 ready after drain", {63'b0, cmd_ready}, 64'd1);
  endtask

  // monitor: drives ready, compares each accepted word against the queue
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = ($urandom % 3) != 0;
      #0.5;
      if (running && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected word", {32'b0, rsp_data}, 64'd0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(rsp_data === it.d, it.tag, {32'b0, rsp_data}, {32'b0, it.d});
          chk(rsp_sop === it.s && rsp_eop === it.e, "R9 marks",
              {62'b0, rsp_sop, rsp_eop}, {62'b0, it.s, it.e});
          chk(cmd_ready === 1'b0, "R10 blocked", {63'b0, cmd_ready}, 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #0.5;
    chk(cmd_ready === 1'b1, "R10 reset ready", {63'b0, cmd_ready}, 64'd1);
    chk(rsp_valid === 1'b0, "R10 reset valid", {63'b0, rsp_valid}, 64'd0);
    running = 1;
    send(4'hF, 4'h1, 11'h000, 11'd0, 0);        // R2, R1 reserved bits cleared
    send(4'h0, 4'hF, 11'h000, 11'd0, 0);        // R1 top ID
    send(4'h0, 4'h2, 11'h010, 11'd0, 0);        // R3
    send(4'h0, 4'h3, 11'h013, 11'd0, 0);        // R3
    send(4'h0, 4'h4, 11'h012, 11'd0, 0);        // R4
    send(4'h0, 4'h5, 11'h018, 11'd1, 32'h1);    // R5 0.75 V
    send(4'h0, 4'h6, 11'h018, 11'd1, 32'hA);    // R5 order
    send(4'h0, 4'h7, 11'h018, 11'd1, 32'hF);    // R5 all
    send(4'h0, 4'h8, 11'h018, 11'd1, 32'h0);    // R8 empty mask
    send(4'h0, 4'h9, 11'h018, 11'd1, 32'h10);   // R8 out-of-range bit
    send(4'h0, 4'hA, 11'h05C, 11'd2, 32'h5);    // R6
    send(4'h0, 4'hB, 11'h7FF, 11'd0, 0);        // R6
    send(4'h0, 4'hC, 11'h010, 11'd1, 32'h1);    // R7
    send(4'h0, 4'hD, 11'h018, 11'd0, 0);        // R7
    send(4'h0, 4'hE, 11'h018, 11'd2, 32'h0);    // R7 ranks above R8
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule